// File: doc/BRIEF.md
# Tile Scanline Pixel Streamer

This block produces the pixel bytes for one scan line of a character-tile display. On a start strobe it walks a row of tile entries held in video RAM, where each entry is a two-byte absolute address of a tile bitmap. It adds the line's vertical offset inside the tile row to each entry and then reads the bitmap bytes one by one from tile memory. Each byte is presented on an 8-bit pixel output for a fixed number of clocks.

Two line geometries are supported: narrow tiles of 6 pixels, giving 40 tiles per line, and wide tiles of 8 pixels, giving 30 tiles per line. The entry for the next tile is read while the current tile is still being shown, so tiles follow one another with no gap. A single black pixel closes the line, and a one-cycle done pulse follows it. Because the row base is only read and never changed, the caller can render the same row again for each of the 8 lines of a tile by raising start with the same base and the next offset.

Top module: `tile_line_renderer`

## Requirements
- R1: After reset, pix is 0, pix_valid and done are low, and neither read strobe is asserted until start is seen.
- R2: wide_mode=0 selects 6 pixels per tile and 40 tiles per line. wide_mode=1 selects 8 pixels per tile and 30 tiles per line. The line therefore carries tiles×pixels+1 pixels, the trailing black one included.
- R3: Entry k of the row is read from video RAM at base_addr+2k as the low byte and at base_addr+2k+1 as the high byte, forming a 16-bit tile address. Both RAM ports return data on the cycle after their read strobe.
- R4: Pixel p of a tile comes from tile memory at entry + y_off×(pixels per tile) + p, with 16-bit wrap. The byte is output unchanged.
- R5: Every pixel is held for exactly 6 clocks. pix_valid stays high without a break from the first pixel to the end of the trailing black pixel.
- R6: The pixel after the last tile is 0 and lasts 6 clocks. While pix_valid is low, pix is 0.
- R7: done is high for exactly one cycle. That cycle is the first one in which pix_valid is low after the trailing black pixel.
- R8: A start raised while a line is in progress is ignored. The current line continues unchanged, and only one done follows.
- R9: Video RAM reads stay within base_addr to base_addr+2×tiles-1. The same base can be rendered again with a new y_off, and the result is the line for that offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin rendering a line (taken only when idle) |
| base_addr | input | 16 | Video RAM address of the row's first entry |
| y_off | input | 3 | Line within the tile row, 0 to 7 |
| wide_mode | input | 1 | 0: 6-pixel tiles, 1: 8-pixel tiles |
| vram_rd | output | 1 | Video RAM read strobe |
| vram_addr | output | 16 | Video RAM byte address |
| vram_data | input | 8 | Video RAM read data, one cycle after the strobe |
| tile_rd | output | 1 | Tile memory read strobe |
| tile_addr | output | 16 | Tile memory byte address |
| tile_data | input | 8 | Tile memory read data, one cycle after the strobe |
| pix | output | 8 | Pixel byte |
| pix_valid | output | 1 | High while a line's pixels are being shown |
| done | output | 1 | One-cycle pulse at the end of the line |

## Verification
The bench gives each entry a different high byte and uses large y offsets, so that offset carries reach the upper address byte. An adder that is too narrow, or a swapped byte order in the entry, then corrupts the stream. It compares the full pixel stream at both widths and counts its length; a design with the wrong tile count or the wrong hold time would give too many or too few cycles. It watches for a drop in pix_valid at tile boundaries, which shows up when the next entry is fetched too late. It also raises a second start in the middle of a line with a different base and width. A design that accepts that start would read outside the row, change the stream and give two done pulses.

// File: rtl/tile_line_renderer.sv
module tile_line_renderer #(
  parameter int AW           = 16,
  parameter int DW           = 8,
  parameter int HOLD         = 6,
  parameter int NARROW_PX    = 6,
  parameter int NARROW_TILES = 40,
  parameter int WIDE_PX      = 8,
  parameter int WIDE_TILES   = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [2:0]    y_off,
  input  logic          wide_mode,
  output logic          vram_rd,
  output logic [AW-1:0] vram_addr,
  input  logic [7:0]    vram_data,
  output logic          tile_rd,
  output logic [AW-1:0] tile_addr,
  input  logic [DW-1:0] tile_data,
  output logic [DW-1:0] pix,
  output logic          pix_valid,
  output logic          done
);
  localparam int MAXPX = (WIDE_PX > NARROW_PX) ? WIDE_PX : NARROW_PX;
  localparam int MAXT  = (WIDE_TILES > NARROW_TILES) ? WIDE_TILES : NARROW_TILES;
  localparam int PHW   = $clog2(HOLD);
  localparam int PXW   = $clog2(MAXPX);
  localparam int TNW   = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_RUN, S_TAIL} st_t;

  st_t           st;
  logic [PHW-1:0] ph;
  logic [PXW-1:0] px, lastpx;
  logic [TNW-1:0] tleft;
  logic [AW-1:0]  vptr, nxt, taddr, ofs;
  logic [7:0]     lo;

  logic slot_end, tile_last, more, fetch;

  assign slot_end  = ph == PHW'(HOLD - 1);
  assign tile_last = px == lastpx;
  assign more      = tleft > TNW'(1);
  assign fetch     = (st == S_PRE) || (st == S_RUN && px == '0 && more);

  assign vram_rd   = fetch && (ph == PHW'(0) || ph == PHW'(1));
  assign vram_addr = (ph == PHW'(1)) ? vptr + AW'(1) : vptr;

  assign tile_rd   = ph == PHW'(HOLD - 2) &&
                     ((st == S_PRE) || (st == S_RUN && !(tile_last && !more)));
  assign tile_addr = (st == S_PRE || tile_last) ? nxt : taddr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ph        <= '0;
      px        <= '0;
      lastpx    <= '0;
      tleft     <= '0;
      vptr      <= '0;
      nxt       <= '0;
      taddr     <= '0;
      ofs       <= '0;
      lo        <= '0;
      pix       <= '0;
      pix_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      ph   <= (st == S_IDLE || slot_end) ? '0 : ph + PHW'(1);

      if (fetch && ph == PHW'(1)) lo <= vram_data;
      if (fetch && ph == PHW'(2)) begin
        nxt  <= {vram_data, lo} + ofs;
        vptr <= vptr + AW'(2);
      end
      if (tile_rd) taddr <= tile_addr + AW'(1);

      case (st)
        S_IDLE: if (start) begin
          st     <= S_PRE;
          px     <= '0;
          vptr   <= base_addr;
          ofs    <= AW'(y_off) * (wide_mode ? AW'(WIDE_PX) : AW'(NARROW_PX));
          lastpx <= wide_mode ? PXW'(WIDE_PX - 1) : PXW'(NARROW_PX - 1);
          tleft  <= wide_mode ? TNW'(WIDE_TILES) : TNW'(NARROW_TILES);
        end
        S_PRE: if (slot_end) begin
          st        <= S_RUN;
          pix       <= tile_data;
          pix_valid <= 1'b1;
        end
        S_RUN: if (slot_end) begin
          if (!tile_last) begin
            px  <= px + PXW'(1);
            pix <= tile_data;
          end else if (more) begin
            px    <= '0;
            tleft <= tleft - TNW'(1);
            pix   <= tile_data;
          end else begin
            st  <= S_TAIL;
            pix <= '0;
          end
        end
        default: if (slot_end) begin
          st        <= S_IDLE;
          pix_valid <= 1'b0;
          done      <= 1'b1;
        end
      endcase
    end
  end
endmodule

module tile_line_renderer_chk #(
  parameter int DW   = 8,
  parameter int HOLD = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] pix,
  input logic          pix_valid,
  input logic          done
);
  logic [7:0] ccnt;

  always_ff @(posedge clk) begin
    if (!rst_n) ccnt <= '0;
    else if (pix_valid) ccnt <= (ccnt == 8'(HOLD - 1)) ? '0 : ccnt + 8'd1;
    else ccnt <= '0;
  end

  p_pixel_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && ccnt != 8'd0) |-> $stable(pix));

  p_valid_ends_on_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pix_valid) |-> ($past(ccnt) == 8'(HOLD - 1) && done));

  p_dark_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix == '0);

  p_black_before_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pix) == '0);

  p_done_at_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $fell(pix_valid));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind tile_line_renderer tile_line_renderer_chk #(.DW(DW), .HOLD(HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix(pix), .pix_valid(pix_valid), .done(done)
);

// File: tb/tile_line_renderer_bench.sv
module tile_line_renderer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] base_addr = '0;
  logic [2:0]  y_off = '0;
  logic        wide_mode = 1'b0;
  logic        vram_rd, tile_rd, pix_valid, done;
  logic [15:0] vram_addr, tile_addr;
  logic [7:0]  vram_data, tile_data, pix;

  logic [7:0] vmem [256];
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_line_renderer u_tile_line_renderer (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .y_off(y_off), .wide_mode(wide_mode), .vram_rd(vram_rd),
    .vram_addr(vram_addr), .vram_data(vram_data), .tile_rd(tile_rd),
    .tile_addr(tile_addr), .tile_data(tile_data), .pix(pix),
    .pix_valid(pix_valid), .done(done)
  );

  function automatic logic [7:0] tile_byte(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd29) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (vram_rd) vram_data <= vmem[vram_addr[7:0]];
    if (tile_rd) tile_data <= tile_byte(tile_addr);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fill_row(input logic [7:0] b, input int n, input logic [15:0] seed);
    for (int i = 0; i < n; i++) begin
      logic [15:0] e;
      e = seed + 16'(i) * 16'h0A37;
      vmem[8'(b + 8'(2*i))]     = e[7:0];
      vmem[8'(b + 8'(2*i + 1))] = e[15:8];
    end
  endtask

  task automatic run_line(input logic [7:0] b, input logic [2:0] y, input bit wide,
                          input int inject_at);
    int n, w, total, idx, mism, gaps, oor, dones, badend, zeros;
    bit seen, prev_v;
    logic [15:0] base16;
    n = wide ? 30 : 40;
    w = wide ? 8 : 6;
    total = (n * w + 1) * 6;
    base16 = {8'h3A, b};
    idx = 0; mism = 0; gaps = 0; oor = 0; dones = 0; badend = 0; zeros = 0;
    seen = 0; prev_v = 0;
    @(negedge clk);
    base_addr = base16; y_off = y; wide_mode = wide; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (cyc == inject_at) begin
        start = 1'b1; base_addr = 16'h7700; wide_mode = !wide; y_off = 3'd1;
      end else start = 1'b0;
      if (vram_rd && (vram_addr < base16 || vram_addr >= base16 + 16'(2*n))) oor++;
      if (pix_valid) begin
        int k;
        logic [7:0] e;
        k = idx / 6;
        if (k >= n * w) begin
          e = 8'h00;
          zeros++;
        end else begin
          int t, p;
          logic [15:0] ent;
          t = k / w; p = k % w;
          ent = {vmem[8'(b + 8'(2*t + 1))], vmem[8'(b + 8'(2*t))]};
          e = tile_byte(ent + 16'(y) * 16'(w) + 16'(p));
        end
        if (pix !== e) begin
          if (mism == 0) $display("FAIL R4: pixel %0d actual %0d expected %0d", idx, pix, e);
          mism++;
        end
        idx++;
        seen = 1;
      end else if (seen && prev_v && !done) gaps++;
      if (done) begin
        dones++;
        if (!(prev_v && !pix_valid)) badend++;
      end
      if (seen && !pix_valid && pix !== 8'h00) badend++;
      prev_v = pix_valid;
      if (dones > 0 && !pix_valid && cyc > inject_at + 8 && !done) begin
        for (int j = 0; j < 4; j++) begin
          @(negedge clk);
          if (done) dones++;
          if (pix_valid || pix !== 8'h00) badend++;
        end
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(mism == 0, "R3/R4 stream content", mism, 0);
    chk(idx == total, "R2 line length in cycles", idx, total);
    chk(gaps == 0, "R5 no gap in pix_valid", gaps, 0);
    chk(zeros == 6, "R6 trailing black cycles", zeros, 6);
    chk(badend == 0, "R6/R7 done timing and idle output", badend, 0);
    chk(dones == 1, "R7 R8 single done pulse", dones, 1);
    chk(oor == 0, "R9 video RAM reads inside row", oor, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(pix == 8'h00 && !pix_valid && !done && !vram_rd && !tile_rd,
          "R1 idle after reset", {pix_valid, done, vram_rd, tile_rd}, 0);
    end
  endtask

  task automatic t_narrow_rows;
    fill_row(8'h04, 40, 16'hA3C0);
    run_line(8'h04, 3'd0, 1'b0, -1);
    run_line(8'h04, 3'd7, 1'b0, -1);
  endtask

  task automatic t_wide_row;
    fill_row(8'h60, 30, 16'hFFD8);
    run_line(8'h60, 3'd5, 1'b1, -1);
  endtask

  task automatic t_start_ignored;
    fill_row(8'h90, 30, 16'h12F4);
    run_line(8'h90, 3'd6, 1'b1, 300);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) vmem[i] = 8'(i * 7);
    t_reset;
    t_narrow_rows;
    t_wide_row;
    t_start_ignored;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule